// File: doc/BRIEF.md
# Watchdog Timer with Low-Power Mode Handling

This block is a watchdog for a small processor system. A free-running counter advances on every clock. When it wraps from all ones back to zero, the block raises a reset request for the whole system. Software prevents this by servicing the watchdog. To service it, software writes a value with bit 0 clear to one fixed bus address. That write clears the counter and starts a new timeout period. With the default 18-bit counter clocked at 4 MHz, the timeout is about 65.5 ms. The block ignores reads of the service address, so the memory mapped behind that address answers them.

The block follows the processor's power state. In the wait and halt states the counter keeps running, so software must wake up from time to time to service it. Entering stop clears the counter and freezes it. A wake request ends stop and starts a fixed start-up delay, during which the counter runs. What happens at the end of the delay depends on the wake source. After an interrupt wake, the counter keeps the cycles it counted during the delay. After a reset wake, the counter is cleared once the delay ends. A build-time parameter can remove the watchdog completely. All state uses a synchronous active-high reset.

Top module: `wdog_top`

## Requirements
- R1: After reset is released, or after a service write, the counter starts from zero. The reset request rises exactly 2^CNT_W clock edges later, on the edge where the counter wraps from all ones to zero.
- R2: `reset_req` is low while `rst` is high and is never high for two cycles in a row.
- R3: A cycle with `bus_wr` high, `bus_addr` equal to 0x1FF0 and `bus_wdata` bit 0 equal to 0 clears the counter, whatever the other data bits are.
- R4: A write to 0x1FF0 with `bus_wdata` bit 0 equal to 1 has no effect on the timeout.
- R5: Writes to any other address, and cycles with `bus_wr` low at 0x1FF0 (reads), have no effect on the timeout. The block has no read-data output.
- R6: In the wait mode (`cpu_mode` = 2'b01) and the halt mode (`cpu_mode` = 2'b10), the counter runs exactly as in run mode (2'b00).
- R7: Setting `cpu_mode` to stop (2'b11) clears the counter on the next edge. The counter is then held at zero and no reset request occurs until a wake.
- R8: A `wake_req` pulse while stopped starts a start-up delay of STARTUP_CYC edges (4064 by default), during which the counter runs. Service writes are honoured only outside stop and outside the start-up delay.
- R9: An interrupt wake (`wake_irq` = 1) keeps the cycles counted during the delay. The reset request then rises 2^CNT_W edges after the wake edge.
- R10: A reset wake (`wake_irq` = 0) clears the counter when the delay ends. The reset request then rises STARTUP_CYC + 2^CNT_W edges after the wake edge.
- R11: With ENABLE = 0, `reset_req` is constantly low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock, twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W (16) | Bus address |
| bus_wdata | input | DATA_W (8) | Bus write data |
| cpu_mode | input | 2 | Power state: 00 run, 01 wait, 10 halt, 11 stop |
| wake_req | input | 1 | One-cycle pulse that ends stop |
| wake_irq | input | 1 | Wake source sampled with `wake_req`: 1 interrupt, 0 reset |
| reset_req | output | 1 | One-cycle system reset request on timeout |

## Verification
Every timing result is an edge count from a reference edge. The reference is the last edge with `rst` high, the edge that takes a service write, or the wake edge. From there the pulse is due 2^CNT_W edges later, or STARTUP_CYC + 2^CNT_W edges later after a reset wake. The bench increments an edge counter on each rising edge. It drives inputs and samples `reset_req` on falling edges, so the edge count read at the first falling edge with the pulse high is exactly the edge that raised it. Comparing that count with the reference gives an exact match, not a window. Ignored stimulus (a set bit 0, a wrong address, a read, a write during start-up) is checked the same way: the pulse must still land on the edge set by the earlier reference. The bench shortens the counter to 13 bits so that every scenario fits in the run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_HALT = 2'b10,
        MODE_STOP = 2'b11
    } cpu_mode_e;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'b00,
        ST_STOPPED = 2'b01,
        ST_STARTUP = 2'b10
    } wd_state_e;

    // control word handed from the mode FSM to the counter
    typedef struct packed {
        logic clr;   // force counter to zero on this edge
        logic en;    // advance counter on this edge
    } cnt_ctrl_t;

    function automatic logic is_stop(input cpu_mode_e m);
        return m == MODE_STOP;
    endfunction

endpackage

// File: rtl/wdog_svc_decode.sv
module wdog_svc_decode #(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter logic [15:0] SVC_ADDR = 16'h1FF0,
    parameter int          SVC_BIT  = 0
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              svc_hit
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(SVC_ADDR);

    // only the service bit matters; the rest of the data is don't-care
    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        svc_hit = bus_wr && (bus_addr == MATCH) && !bus_wdata[SVC_BIT];
    end
endmodule

// File: rtl/wdog_startup.sv
module wdog_startup #(
    parameter int STARTUP_CYC = 4064
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int DLY_W = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
    localparam logic [DLY_W-1:0] LOAD = DLY_W'(STARTUP_CYC - 1);

    logic [DLY_W-1:0] dly_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= '0;
            run_q <= 1'b0;
        end else if (start_i) begin
            dly_q <= LOAD;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (dly_q == '0) begin
                run_q <= 1'b0;
            end else begin
                dly_q <= dly_q - 1'b1;
            end
        end
    end

    assign busy_o = run_q;
    assign done_o = run_q && (dly_q == '0);

    AST_DELAY_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (dly_q <= LOAD)); // R8
    AST_DELAY_RELOAD: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (run_q && dly_q == LOAD)); // R8
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctrl_t        ctrl_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             wrap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (ctrl_i.clr) begin
                cnt_q <= '0;
            end else if (ctrl_i.en) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == ALL_ONES) begin
                    wrap_q <= 1'b1;
                end
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = wrap_q;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        ctrl_i.clr |=> (cnt_q == '0)); // R3
    AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap_q |-> (cnt_q == '0)); // R1
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_i.clr && !ctrl_i.en) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter bit          ENABLE      = 1'b1,
    parameter int          CNT_W       = 18,
    parameter int          STARTUP_CYC = 4064,
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 8,
    parameter logic [15:0] SVC_ADDR    = 16'h1FF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        cpu_mode,
    input  logic              wake_req,
    input  logic              wake_irq,
    output logic              reset_req
);
    generate
        if (ENABLE) begin : g_wdog
            wd_state_e        state_q;
            logic             irq_src_q;
            logic             svc_hit;
            logic             dly_busy;
            logic             dly_done;
            logic             stop_enter;
            logic             wake_take;
            cnt_ctrl_t        ctrl;
            logic [CNT_W-1:0] cnt;
            logic             wrap;

            wdog_svc_decode #(
                .ADDR_W  (ADDR_W),
                .DATA_W  (DATA_W),
                .SVC_ADDR(SVC_ADDR),
                .SVC_BIT (0)
            ) u_dec (
                .bus_wr   (bus_wr),
                .bus_addr (bus_addr),
                .bus_wdata(bus_wdata),
                .svc_hit  (svc_hit)
            );

            assign stop_enter = (state_q == ST_ACTIVE) && is_stop(cpu_mode_e'(cpu_mode));
            assign wake_take  = (state_q == ST_STOPPED) && wake_req;

            wdog_startup #(
                .STARTUP_CYC(STARTUP_CYC)
            ) u_dly (
                .clk    (clk),
                .rst    (rst),
                .start_i(wake_take),
                .busy_o (dly_busy),
                .done_o (dly_done)
            );

            // mode sequencing: active -> stopped -> start-up -> active
            always_ff @(posedge clk) begin
                if (rst) begin
                    state_q   <= ST_ACTIVE;
                    irq_src_q <= 1'b0;
                end else begin
                    unique case (state_q)
                        ST_ACTIVE: begin
                            if (stop_enter) state_q <= ST_STOPPED;
                        end
                        ST_STOPPED: begin
                            if (wake_take) begin
                                state_q   <= ST_STARTUP;
                                irq_src_q <= wake_irq;
                            end
                        end
                        ST_STARTUP: begin
                            if (dly_done) state_q <= ST_ACTIVE;
                        end
                        default: state_q <= ST_ACTIVE;
                    endcase
                end
            end

            always_comb begin
                ctrl.en  = (state_q != ST_STOPPED);
                ctrl.clr = 1'b0;
                if (state_q == ST_ACTIVE && (svc_hit || stop_enter)) ctrl.clr = 1'b1;
                if (state_q == ST_STARTUP && dly_done && !irq_src_q) ctrl.clr = 1'b1;
            end

            wdog_counter #(
                .CNT_W(CNT_W)
            ) u_cnt (
                .clk   (clk),
                .rst   (rst),
                .ctrl_i(ctrl),
                .cnt_o (cnt),
                .wrap_o(wrap)
            );

            assign reset_req = wrap;

            AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
                reset_req |=> !reset_req); // R2
            AST_STOP_HELD: assert property (@(posedge clk) disable iff (rst)
                (state_q == ST_STOPPED) |-> (cnt == '0 && !reset_req)); // R7
            AST_STARTUP_TRACK: assert property (@(posedge clk) disable iff (rst)
                (state_q == ST_STARTUP) |-> dly_busy); // R8
            AST_IRQ_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
                ($past(state_q) == ST_STARTUP && state_q == ST_ACTIVE && irq_src_q)
                |-> (cnt == CNT_W'(STARTUP_CYC))); // R9
            AST_RST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
                ($past(state_q) == ST_STARTUP && state_q == ST_ACTIVE && !irq_src_q)
                |-> (cnt == '0)); // R10
        end else begin : g_none
            logic unused_in;
            assign unused_in = ^{clk, rst, bus_wr, bus_addr, bus_wdata,
                                 cpu_mode, wake_req, wake_irq};
            assign reset_req = 1'b0;
        end
    endgenerate

    always_comb begin
        if (!ENABLE) begin
            AST_REMOVED_QUIET: assert (reset_req == 1'b0); // R11
        end
    end
endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
    localparam int CLK_NS  = 10;
    localparam int W       = 13;
    localparam int PERIOD  = 1 << W;
    localparam int STARTUP = 4064;
    localparam logic [15:0] SVC = 16'h1FF0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [1:0]  cpu_mode = 2'b00;
    logic        wake_req = 1'b0;
    logic        wake_irq = 1'b0;
    logic        rr;
    logic        rr_off;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit off_seen = 1'b0;

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_top #(.CNT_W(W), .STARTUP_CYC(STARTUP)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cpu_mode(cpu_mode), .wake_req(wake_req),
        .wake_irq(wake_irq), .reset_req(rr));

    wdog_top #(.ENABLE(1'b0), .CNT_W(W), .STARTUP_CYC(STARTUP)) u1 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cpu_mode(cpu_mode), .wake_req(wake_req),
        .wake_irq(wake_irq), .reset_req(rr_off));

    always @(negedge clk) if (rr_off) off_seen = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one bus write; returns the edge count of the edge that took it
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, output int at);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        at = cyc;
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // returns edge count at which reset_req first seen high
    task automatic wait_pulse(output int at);
        at = -1;
        for (int i = 0; i < 3 * PERIOD; i++) begin
            @(negedge clk);
            if (rr) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic t_reset;
        int ref_e, p;
        repeat (3) @(negedge clk);
        chk(rr == 1'b0, "R2 low in reset", int'(rr), 0);
        rst = 1'b0;
        ref_e = cyc;
        wait_pulse(p);
        chk(p == ref_e + PERIOD, "R1 first timeout after reset", p - ref_e, PERIOD);
        @(negedge clk);
        chk(rr == 1'b0, "R2 single-cycle pulse", int'(rr), 0);
    endtask

    task automatic t_service;
        int w, p;
        idle(100);
        bus_write(SVC, 8'hFE, w);
        wait_pulse(p);
        chk(p == w + PERIOD, "R3 service restarts period", p - w, PERIOD);
    endtask

    task automatic t_ignored;
        int w, x, p;
        bus_write(SVC, 8'h00, w);
        idle(2000);
        bus_write(SVC, 8'h01, x);          // R4 bit 0 set
        idle(500);
        bus_write(16'h1FF1, 8'h00, x);     // R5 wrong address
        @(negedge clk);                    // R5 read cycle
        bus_addr = SVC; bus_wdata = 8'h00;
        @(negedge clk);
        bus_addr = '0;
        wait_pulse(p);
        chk(p == w + PERIOD, "R4 R5 ignored accesses", p - w, PERIOD);
    endtask

    task automatic t_wait_halt;
        int w, p;
        bus_write(SVC, 8'h00, w);
        cpu_mode = 2'b01;
        idle(2000);
        cpu_mode = 2'b10;
        wait_pulse(p);
        chk(p == w + PERIOD, "R6 counts in wait and halt", p - w, PERIOD);
        cpu_mode = 2'b00;
    endtask

    task automatic t_stop(input bit irq);
        int w, wk, p, hits;
        bus_write(SVC, 8'h00, w);
        idle(1000);
        @(negedge clk);
        cpu_mode = 2'b11;
        hits = 0;
        for (int i = 0; i < PERIOD + 2000; i++) begin
            @(negedge clk);
            if (rr) hits++;
        end
        chk(hits == 0, "R7 no timeout while stopped", hits, 0);
        cpu_mode = 2'b00; wake_req = 1'b1; wake_irq = irq;
        @(negedge clk);
        wk = cyc;
        wake_req = 1'b0; wake_irq = 1'b0;
        idle(100);
        bus_write(SVC, 8'h00, w);          // R8 write during start-up
        wait_pulse(p);
        if (irq)
            chk(p == wk + PERIOD, "R8 R9 interrupt wake keeps count", p - wk, PERIOD);
        else
            chk(p == wk + STARTUP + PERIOD, "R8 R10 reset wake clears count",
                p - wk, STARTUP + PERIOD);
    endtask

    initial begin
        t_reset();
        t_service();
        t_ignored();
        t_wait_halt();
        t_stop(1'b1);
        t_stop(1'b0);
        chk(off_seen == 1'b0, "R11 disabled build never requests", int'(off_seen), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule